// File: doc/BRIEF.md
# Code Read Protection Access Filter

This block sits beside the boot and programming logic and decides, once per power cycle, how much outside access the chip permits. Right after power-on reset it fetches one 32-bit protection word from a fixed flash location. It compares that word against three magic values to pick a protection level, and keeps that level until the next power-on reset. Writes to flash after that point do not change the active level.

The stored level controls three things. It gates the debug-port enable. It gates the boot-entry pin request. It also judges every in-system-programming (ISP) command the boot firmware presents. A request carries an opcode, a target address, a sector number, an all-sectors flag and a marker for in-application (IAP) origin. The filter answers allow or deny one clock later. IAP requests are always allowed. Running the commands, flash timing and the serial transport belong to other blocks.

Top module: `crp_access_filter`

## Requirements
- R1: After reset deasserts, `flash_rd_en` is high and `flash_rd_addr` is 0x000001FC until the first cycle with `flash_rd_valid` high. In the next cycle `ready` is 1 and `flash_rd_en` is 0. Until then `ready` is 0.
- R2: The captured word sets `prot_level`: 0x12345678 gives 1, 0x87654321 gives 2, 0x43218765 gives 3, and any other value gives 0. Before capture `prot_level` reads 0.
- R3: Once `ready` is 1, further `flash_rd_valid` pulses with any data leave `prot_level` unchanged until the next reset.
- R4: `debug_en` is 1 only when `ready` is 1 and `prot_level` is 0.
- R5: Each `req_valid` cycle produces exactly one `resp_valid` cycle on the next clock, carrying `resp_allow`. An ISP request (`req_iap`=0) presented while `ready` is 0 is denied.
- R6: A request with `req_iap`=1 is allowed at every level, including before `ready`.
- R7: Opcodes (4 bits) are 0 read, 1 write-RAM, 2 go, 3 copy-to-flash, 4 compare, 5 erase, 6 prepare, and 7 to 15 other. At level 0 every ready ISP request is allowed. Prepare and other opcodes are allowed at every level once ready.
- R8: At level 1, read and compare are denied. Write-RAM is denied when `req_addr` < 0x40000200 and allowed at or above it. Go is allowed.
- R9: At level 1, copy-to-flash to sector 0 is denied, and to any other sector it is allowed. Erase with `req_sector`=0 is allowed only when `req_all_sectors`=1. Erase of other sectors is allowed.
- R10: At level 2, read, write-RAM, go, copy-to-flash and compare are denied. Erase is allowed only when `req_all_sectors`=1.
- R11: At level 3, ISP opcodes are not filtered. `boot_entry` is 0 whenever `user_code_valid` is 1.
- R12: `boot_entry` equals `boot_pin_req` when `ready` is 1 and the level-3 condition of R11 does not apply. It is 0 while `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| flash_rd_en | output | 1 | Request for the protection-word read |
| flash_rd_addr | output | 32 | Byte address of the protection word |
| flash_rd_data | input | 32 | Read data from flash |
| flash_rd_valid | input | 1 | Read data valid |
| req_valid | input | 1 | Request strobe |
| req_iap | input | 1 | Request comes from in-application programming |
| req_op | input | 4 | Command opcode |
| req_addr | input | 32 | Target address (RAM write) |
| req_sector | input | 5 | Target sector |
| req_all_sectors | input | 1 | Request covers every sector |
| resp_valid | output | 1 | Decision valid |
| resp_allow | output | 1 | 1 allow, 0 deny |
| ready | output | 1 | Protection level is loaded |
| prot_level | output | 2 | Active protection level |
| debug_en | output | 1 | Debug-port enable |
| boot_pin_req | input | 1 | Boot-entry pin asserted |
| user_code_valid | input | 1 | Valid user code present in sector 0 |
| boot_entry | output | 1 | Boot-entry request honoured |

## Verification
The hardest case to reach is a late flash read return that could overwrite the level. Normal operation produces no such event, so the bench creates it on purpose. After each load it pulses the read-valid strobe again with a different magic word. It then confirms that the level, debug enable and command decisions keep their old values. Each level needs its own power cycle, so the bench repeats reset with each magic word and one non-magic word. The read latency varies between cycles. During each wait the bench sends requests to cover the not-ready denial and the IAP bypass.

// File: rtl/crp_pkg.sv
// Shared types and constants for the code read protection filter.
// Assumes a 32-bit flash/RAM address space and a 4-bit command opcode.
package crp_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_TWO  = 2'd2,
        LVL_THREE = 2'd3
    } prot_lvl_t;

    localparam logic [3:0] OP_READ  = 4'd0;
    localparam logic [3:0] OP_WRRAM = 4'd1;
    localparam logic [3:0] OP_GO    = 4'd2;
    localparam logic [3:0] OP_COPY  = 4'd3;
    localparam logic [3:0] OP_CMP   = 4'd4;
    localparam logic [3:0] OP_ERASE = 4'd5;
    localparam logic [3:0] OP_PREP  = 4'd6;

    localparam logic [31:0] MAGIC_ONE   = 32'h1234_5678;
    localparam logic [31:0] MAGIC_TWO   = 32'h8765_4321;
    localparam logic [31:0] MAGIC_THREE = 32'h4321_8765;

endpackage

// File: rtl/crp_word_loader.sv
// Fetches the protection word once after power-on reset and holds it.
// Assumes flash answers the held read request with a one-cycle valid
// strobe; any valid strobe after the capture is ignored until reset.
module crp_word_loader #(
    parameter int              ADDR_W   = 32,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] WORD_ADDR = 'h1FC
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic [DATA_W-1:0] word_q,
    output logic              loaded
);

    typedef enum logic {ST_FETCH, ST_DONE} ld_state_t;
    ld_state_t state_q;

    // Purpose: one-shot capture of the protection word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            word_q  <= '0;
        end else if (state_q == ST_FETCH && rd_valid) begin
            state_q <= ST_DONE;
            word_q  <= rd_data;
        end
    end

    // Purpose: drive the read request and the loaded flag from the state.
    always_comb begin
        rd_en   = (state_q == ST_FETCH);
        rd_addr = WORD_ADDR;
        loaded  = (state_q == ST_DONE);
    end

    a_r1_ready_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!loaded && rd_valid) |=> loaded);
    a_r1_no_read_when_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |-> !rd_en);
    a_r3_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && $past(loaded)) |-> $stable(word_q));

endmodule

// File: rtl/crp_level_decode.sv
// Maps the captured protection word onto a level by exact magic match.
// Assumes the word is stable once loaded; purely combinational.
module crp_level_decode
    import crp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    output prot_lvl_t         level
);

    // Purpose: exact compare against the three magic values.
    always_comb begin
        if (word == DATA_W'(MAGIC_ONE))        level = LVL_ONE;
        else if (word == DATA_W'(MAGIC_TWO))   level = LVL_TWO;
        else if (word == DATA_W'(MAGIC_THREE)) level = LVL_THREE;
        else                                   level = LVL_NONE;
    end

endmodule

// File: rtl/crp_isp_judge.sv
// Judges one programming request per strobe and registers the verdict.
// Assumes level is stable while loaded; the answer follows in one cycle.
module crp_isp_judge
    import crp_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              SECT_W    = 5,
    parameter logic [ADDR_W-1:0] RAM_FENCE = 'h4000_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loaded,
    input  prot_lvl_t         level,
    input  logic              req_valid,
    input  logic              req_iap,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SECT_W-1:0] req_sector,
    input  logic              req_all,
    output logic              resp_valid,
    output logic              resp_allow
);

    logic allow_d;
    logic sect_zero;
    logic below_fence;

    // Purpose: helper conditions shared by the level rules.
    always_comb begin
        sect_zero   = (req_sector == '0);
        below_fence = (req_addr < RAM_FENCE);
    end

    // Purpose: apply the rules of the active level to the request.
    always_comb begin
        allow_d = 1'b1;
        if (req_iap) begin
            allow_d = 1'b1;
        end else if (!loaded) begin
            allow_d = 1'b0;
        end else begin
            case (level)
                LVL_ONE: begin
                    case (req_op)
                        OP_READ, OP_CMP: allow_d = 1'b0;
                        OP_WRRAM:        allow_d = !below_fence;
                        OP_COPY:         allow_d = !sect_zero;
                        OP_ERASE:        allow_d = !sect_zero || req_all;
                        default:         allow_d = 1'b1;
                    endcase
                end
                LVL_TWO: begin
                    case (req_op)
                        OP_READ, OP_WRRAM, OP_GO, OP_COPY, OP_CMP: allow_d = 1'b0;
                        OP_ERASE: allow_d = req_all;
                        default:  allow_d = 1'b1;
                    endcase
                end
                default: allow_d = 1'b1;
            endcase
        end
    end

    // Purpose: register the verdict one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) resp_allow <= allow_d;
        end
    end

    a_r5_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    a_r5_notready_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !loaded && !req_iap) |=> !resp_allow);
    a_r6_iap_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_iap) |=> resp_allow);
    a_r10_two_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && loaded && !req_iap && level == LVL_TWO && req_op == OP_READ)
        |=> !resp_allow);

endmodule

// File: rtl/crp_access_filter.sv
// Top of the code read protection filter: loads the level once per power
// cycle, gates debug and boot entry, and judges programming requests.
// Assumes rst_n is the power-on reset; no other event reloads the level.
module crp_access_filter
    import crp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SECT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              flash_rd_en,
    output logic [ADDR_W-1:0] flash_rd_addr,
    input  logic [DATA_W-1:0] flash_rd_data,
    input  logic              flash_rd_valid,
    input  logic              req_valid,
    input  logic              req_iap,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SECT_W-1:0] req_sector,
    input  logic              req_all_sectors,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              ready,
    output logic [1:0]        prot_level,
    output logic              debug_en,
    input  logic              boot_pin_req,
    input  logic              user_code_valid,
    output logic              boot_entry
);

    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(32'h0000_01FC);
    localparam logic [ADDR_W-1:0] RAM_FENCE = ADDR_W'(32'h4000_0200);

    logic [DATA_W-1:0] word_q;
    logic              loaded;
    prot_lvl_t         level;

    crp_word_loader #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_ADDR(WORD_ADDR)
    ) u_loader (
        .clk(clk), .rst_n(rst_n),
        .rd_en(flash_rd_en), .rd_addr(flash_rd_addr),
        .rd_data(flash_rd_data), .rd_valid(flash_rd_valid),
        .word_q(word_q), .loaded(loaded)
    );

    crp_level_decode #(.DATA_W(DATA_W)) u_decode (
        .word(word_q), .level(level)
    );

    crp_isp_judge #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .RAM_FENCE(RAM_FENCE)
    ) u_judge (
        .clk(clk), .rst_n(rst_n), .loaded(loaded), .level(level),
        .req_valid(req_valid), .req_iap(req_iap), .req_op(req_op),
        .req_addr(req_addr), .req_sector(req_sector), .req_all(req_all_sectors),
        .resp_valid(resp_valid), .resp_allow(resp_allow)
    );

    // Purpose: status, debug gate and boot-entry gate from the held level.
    always_comb begin
        ready      = loaded;
        prot_level = level;
        debug_en   = loaded && (level == LVL_NONE);
        boot_entry = loaded && boot_pin_req &&
                     !((level == LVL_THREE) && user_code_valid);
    end

    a_r4_debug_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_level != 2'd0) |-> !debug_en);
    a_r11_boot_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_level == 2'd3 && user_code_valid) |-> !boot_entry);
    a_r12_boot_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !boot_entry);

endmodule

// File: tb/crp_access_filter_test.sv
module crp_access_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flash_rd_en;
    logic [31:0] flash_rd_addr;
    logic [31:0] flash_rd_data = '0;
    logic        flash_rd_valid = 1'b0;
    logic        req_valid = 1'b0, req_iap = 1'b0;
    logic [3:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_sector = '0;
    logic        req_all_sectors = 1'b0;
    logic        resp_valid, resp_allow, ready, debug_en, boot_entry;
    logic [1:0]  prot_level;
    logic        boot_pin_req = 1'b0, user_code_valid = 1'b0;

    int checks = 0, failures = 0;
    bit    q_allow[$];
    string q_tag[$];
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    crp_access_filter uut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: present one request and push the expected verdict.
    task automatic send(input bit iap, input logic [3:0] op, input logic [31:0] a,
                        input logic [4:0] s, input bit all, input bit exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_iap = iap; req_op = op; req_addr = a;
        req_sector = s; req_all_sectors = all;
        q_allow.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0; req_iap = 1'b0;
    endtask

    // Monitor: pop and compare each verdict as it appears.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (q_allow.size() == 0) check(1'b0, "R5 unexpected response", 1, 0);
            else begin
                bit e; string t;
                e = q_allow.pop_front(); t = q_tag.pop_front();
                check(resp_allow == e, t, resp_allow, e);
            end
        end
    end

    task automatic power_on(input logic [31:0] w, input int lat, input int exp_lvl);
        @(negedge clk); rst_n = 1'b0; flash_rd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(flash_rd_en && flash_rd_addr == 32'h1FC, "R1 read request", flash_rd_addr, 32'h1FC);
        check(!ready && prot_level == 2'd0 && !debug_en, "R2 pre-load status", prot_level, 0);
        send(1'b0, crp_pkg::OP_PREP, 0, 1, 1'b0, 1'b0, "R5 not-ready deny");
        send(1'b1, crp_pkg::OP_READ, 0, 0, 1'b0, 1'b1, "R6 iap before ready");
        boot_pin_req = 1'b1; #1;
        check(!boot_entry, "R12 boot before ready", boot_entry, 0);
        boot_pin_req = 1'b0;
        repeat (lat) @(negedge clk);
        check(!ready && flash_rd_en, "R1 waiting", ready, 0);
        flash_rd_data = w; flash_rd_valid = 1'b1;
        @(negedge clk);
        flash_rd_valid = 1'b0;
        check(ready && !flash_rd_en, "R1 loaded", ready, 1);
        check(prot_level == exp_lvl[1:0], "R2 level decode", prot_level, exp_lvl);
        check(debug_en == (exp_lvl == 0), "R4 debug enable", debug_en, exp_lvl == 0);
        // late flash return must not change the level
        flash_rd_data = (exp_lvl == 2) ? 32'h1234_5678 : 32'h8765_4321;
        flash_rd_valid = 1'b1;
        @(negedge clk);
        flash_rd_valid = 1'b0;
        @(negedge clk);
        check(prot_level == exp_lvl[1:0], "R3 level held", prot_level, exp_lvl);
    endtask

    initial begin
        #400000;
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Level 0
        power_on(32'h1234_5679, 2, 0);
        for (int op = 0; op < 8; op++)
            send(1'b0, 4'(op), 0, 0, 1'b0, 1'b1, "R7 level0 allow");
        boot_pin_req = 1'b1; user_code_valid = 1'b1; #1;
        check(boot_entry, "R12 boot level0", boot_entry, 1);
        boot_pin_req = 1'b0; user_code_valid = 1'b0;
        // Level 1
        power_on(32'h1234_5678, 5, 1);
        send(1'b0, crp_pkg::OP_READ, 0, 3, 1'b0, 1'b0, "R8 l1 read");
        send(1'b0, crp_pkg::OP_CMP, 0, 3, 1'b0, 1'b0, "R8 l1 compare");
        send(1'b0, crp_pkg::OP_WRRAM, 32'h4000_01FF, 0, 1'b0, 1'b0, "R8 l1 below fence");
        send(1'b0, crp_pkg::OP_WRRAM, 32'h4000_0200, 0, 1'b0, 1'b1, "R8 l1 at fence");
        send(1'b0, crp_pkg::OP_GO, 0, 0, 1'b0, 1'b1, "R8 l1 go");
        send(1'b0, crp_pkg::OP_COPY, 0, 0, 1'b0, 1'b0, "R9 l1 copy s0");
        send(1'b0, crp_pkg::OP_COPY, 0, 1, 1'b0, 1'b1, "R9 l1 copy s1");
        send(1'b0, crp_pkg::OP_ERASE, 0, 0, 1'b0, 1'b0, "R9 l1 erase s0");
        send(1'b0, crp_pkg::OP_ERASE, 0, 0, 1'b1, 1'b1, "R9 l1 erase all");
        send(1'b0, crp_pkg::OP_ERASE, 0, 4, 1'b0, 1'b1, "R9 l1 erase s4");
        send(1'b0, 4'd9, 0, 0, 1'b0, 1'b1, "R7 l1 other");
        send(1'b1, crp_pkg::OP_READ, 0, 0, 1'b0, 1'b1, "R6 l1 iap");
        // Level 2
        power_on(32'h8765_4321, 1, 2);
        for (int op = 0; op < 5; op++)
            send(1'b0, 4'(op), 32'h4000_1000, 2, 1'b1, 1'b0, "R10 l2 deny");
        send(1'b0, crp_pkg::OP_ERASE, 0, 2, 1'b0, 1'b0, "R10 l2 erase partial");
        send(1'b0, crp_pkg::OP_ERASE, 0, 0, 1'b1, 1'b1, "R10 l2 erase all");
        send(1'b0, crp_pkg::OP_PREP, 0, 0, 1'b0, 1'b1, "R7 l2 prepare");
        send(1'b1, crp_pkg::OP_COPY, 0, 0, 1'b0, 1'b1, "R6 l2 iap");
        // Level 3
        power_on(32'h4321_8765, 3, 3);
        send(1'b0, crp_pkg::OP_READ, 0, 0, 1'b0, 1'b1, "R11 l3 read");
        send(1'b0, crp_pkg::OP_ERASE, 0, 0, 1'b0, 1'b1, "R11 l3 erase");
        @(negedge clk);
        boot_pin_req = 1'b1; user_code_valid = 1'b1; #1;
        check(!boot_entry, "R11 l3 boot blocked", boot_entry, 0);
        user_code_valid = 1'b0; #1;
        check(boot_entry, "R12 l3 boot no code", boot_entry, 1);
        boot_pin_req = 1'b0; #1;
        check(!boot_entry, "R12 no pin", boot_entry, 0);
        repeat (3) @(negedge clk);
        check(q_allow.size() == 0, "R5 all responses seen", q_allow.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule